// File: doc/BRIEF.md
# Periodic Tick and Interrupt Flag Unit

This unit runs on a 32.768 kHz timekeeping clock. It derives a periodic tick strobe from a free-running divider, and the tick period is a power of two that a 3-bit select input picks. It also keeps two sticky interrupt flags. One is for the alarm, which a match pulse from the calendar counter sets. The other is for the tick. Software clears either flag by writing a one to its bit.

Each flag has its own enable. The enabled flags are ORed into a single interrupt request. The same gated value drives a wake-up request that the power controller uses while the chip is idle or powered down. Calendar counting and bus decoding sit outside this unit. The flag-clear input stands for an already-decoded register write: a strobe plus a two-bit data field.

Top module: `rtc_tick_irq`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `flags`, `irq` and `wakeReq` are 0. The divider restarts from zero, so the first tick comes on cycle P-1 after release, where P is the selected period.
- R2: A `tickSel` value k (0..7) selects a tick period of 32768 >> k clock cycles. This gives 1 s for code 0 and 1/128 s (256 cycles) for code 7.
- R3: The divider never stops and is never restarted by a change of `tickSel`. `tickPulse` is high for exactly one cycle, on every cycle where (cycles since reset + 1) is a multiple of the selected period.
- R4: The tick flag, at position 1 of `flags`, becomes 1 on the clock edge that ends a cycle in which `tickPulse` is high.
- R5: The alarm flag, at position 0 of `flags`, becomes 1 on the clock edge that ends a cycle in which `alarmHit` is high.
- R6: A cycle with `clrWr` high clears, at its closing edge, each flag whose bit in `clrData` is 1 (bit 0 alarm, bit 1 tick). A bit of 0 leaves its flag unchanged. With no set and no clear, a flag holds its value.
- R7: If a set event and a clear of the same flag fall in the same cycle, the flag is 1 after the edge.
- R8: `irq` is high when any flag is 1 and its bit in `intEn` is 1 (bit 0 alarm, bit 1 tick). A flag whose enable is 0 stays set, and it raises `irq` as soon as its enable goes to 1.
- R9: `wakeReq` follows the same enable gating as `irq` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickSel | input | 3 | Tick period code, period = 32768 >> code cycles |
| alarmHit | input | 1 | One-cycle pulse when the time and date equal the alarm setting |
| intEn | input | 2 | Interrupt enables, bit 0 alarm, bit 1 tick |
| clrWr | input | 1 | Flag-clear write strobe |
| clrData | input | 2 | Write-one-to-clear data, bit 0 alarm, bit 1 tick |
| tickPulse | output | 1 | One-cycle periodic tick strobe |
| flags | output | 2 | Sticky flags, bit 0 alarm, bit 1 tick |
| irq | output | 1 | Combined interrupt request |
| wakeReq | output | 1 | Wake-up request for idle and power-down modes |

## Verification
Two kinds of same-cycle collision are possible: a set event can land in the same cycle as a write-one-to-clear of that flag, and the two sources can also fire together. The bench provokes the first by watching `tickPulse` and issuing the tick-flag clear in that very cycle, and by pulsing `alarmHit` together with an alarm clear. After the edge it expects the flag still set. A behavioural model that tracks cycle counts and per-flag next state judges every cycle, so a clear that beats the set, or a tick that lands off its period, shows up as a mismatch at the cycle where it happens.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  // Flag sources and their bit positions in flags, intEn and clrData
  localparam int SRC_COUNT = 2;
  localparam int ALARM_IDX = 0;
  localparam int TICK_IDX  = 1;

  // Strobes from control to the flag datapath
  typedef struct packed {
    logic [SRC_COUNT-1:0] setEv;
    logic [SRC_COUNT-1:0] clrEv;
  } flagStrobes_t;

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV_BITS = 15
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [DIV_BITS-1:0] cnt
);

  // Free-running divider; it is never reloaded, so changing the tick code keeps the phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rtc_tick_ctrl.sv
module rtc_tick_ctrl
  import rtc_tick_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int SEL_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_BITS-1:0]  cnt,
  input  logic [SEL_W-1:0]     tickSel,
  input  logic                 alarmHit,
  input  logic                 clrWr,
  input  logic [SRC_COUNT-1:0] clrData,
  output logic                 tickPulse,
  output flagStrobes_t         strobes
);

  localparam int NUM_SEL = 1 << SEL_W;

  logic [NUM_SEL-1:0] selHit;

  // Code k ticks when the low (DIV_BITS-k) divider bits are all ones
  for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
    assign selHit[k] = &cnt[DIV_BITS-1-k:0];
  end

  assign tickPulse = selHit[tickSel];

  always_comb begin
    strobes = '0;
    strobes.setEv[ALARM_IDX] = alarmHit;
    strobes.setEv[TICK_IDX]  = tickPulse;
    strobes.clrEv            = clrWr ? clrData : '0;
  end

  // R3: a tick never lasts more than one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> !tickPulse);

endmodule

// File: rtl/rtc_tick_flags.sv
module rtc_tick_flags
  import rtc_tick_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStrobes_t         strobes,
  input  logic [SRC_COUNT-1:0] intEn,
  output logic [SRC_COUNT-1:0] flags,
  output logic                 irq,
  output logic                 wakeReq
);

  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_flag
    // Set has priority over clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  flags[i] <= 1'b0;
      else if (strobes.setEv[i])  flags[i] <= 1'b1;
      else if (strobes.clrEv[i])  flags[i] <= 1'b0;
    end

    // R7: a set event always leaves the flag high
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setEv[i] |=> flags[i]);
    // R6: a clear without a set drops the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrEv[i] && !strobes.setEv[i]) |=> !flags[i]);
    // R6: no event, no change
    a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.clrEv[i] && !strobes.setEv[i]) |=> $stable(flags[i]));
  end

  logic anyEnabled;
  assign anyEnabled = |(flags & intEn);
  assign irq        = anyEnabled;
  assign wakeReq    = anyEnabled;

endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq
  import rtc_tick_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int SEL_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     tickSel,
  input  logic                 alarmHit,
  input  logic [SRC_COUNT-1:0] intEn,
  input  logic                 clrWr,
  input  logic [SRC_COUNT-1:0] clrData,
  output logic                 tickPulse,
  output logic [SRC_COUNT-1:0] flags,
  output logic                 irq,
  output logic                 wakeReq
);

  logic [DIV_BITS-1:0] divCnt;
  flagStrobes_t        strobes;

  rtc_tick_div #(.DIV_BITS(DIV_BITS)) u_div (
    .clk  (clk),
    .rstN (rstN),
    .cnt  (divCnt)
  );

  rtc_tick_ctrl #(.DIV_BITS(DIV_BITS), .SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cnt       (divCnt),
    .tickSel   (tickSel),
    .alarmHit  (alarmHit),
    .clrWr     (clrWr),
    .clrData   (clrData),
    .tickPulse (tickPulse),
    .strobes   (strobes)
  );

  rtc_tick_flags u_flags (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .intEn   (intEn),
    .flags   (flags),
    .irq     (irq),
    .wakeReq (wakeReq)
  );

  // R8: with no flag set there is no request
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (flags == '0) |-> (!irq && !wakeReq));
  // R9: wake-up follows the interrupt gating
  a_r9_wake_tracks: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq == irq);
  // R4: a tick leaves the tick flag set
  a_r4_tick_sets: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> flags[TICK_IDX]);
  // R5: an alarm match leaves the alarm flag set
  a_r5_alarm_sets: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> flags[ALARM_IDX]);

endmodule

// File: tb/rtc_tick_irq_test.sv
module rtc_tick_irq_test;

  localparam int FULL = 32768;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] tickSel = 3'd7;
  logic       alarmHit = 1'b0;
  logic [1:0] intEn = 2'b00;
  logic       clrWr = 1'b0;
  logic [1:0] clrData = 2'b00;
  logic       tickPulse;
  logic [1:0] flags;
  logic       irq;
  logic       wakeReq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Behavioural reference state
  int         mCnt = 0;
  logic [1:0] mFlags = 2'b00;

  always #4 clk = ~clk;

  rtc_tick_irq uut (
    .clk(clk), .rstN(rstN), .tickSel(tickSel), .alarmHit(alarmHit),
    .intEn(intEn), .clrWr(clrWr), .clrData(clrData),
    .tickPulse(tickPulse), .flags(flags), .irq(irq), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison and model update, away from the active edge
  always @(negedge clk) begin
    int  period;
    bit  expTick;
    logic [1:0] setV;
    logic [1:0] nxt;
    period  = FULL >> tickSel;
    expTick = rstN && (((mCnt + 1) % period) == 0);
    check("R2/R3", "tickPulse", int'(tickPulse), int'(expTick));
    check("R4", "tick flag", int'(flags[1]), int'(mFlags[1]));
    check("R5", "alarm flag", int'(flags[0]), int'(mFlags[0]));
    check("R8", "irq", int'(irq), int'(|(mFlags & intEn)));
    check("R9", "wakeReq", int'(wakeReq), int'(|(mFlags & intEn)));
    if (!rstN) begin
      mCnt = 0;
      mFlags = 2'b00;
    end else begin
      setV = {expTick, alarmHit};
      for (int i = 0; i < 2; i++) begin
        if (setV[i])                   nxt[i] = 1'b1;
        else if (clrWr && clrData[i])  nxt[i] = 1'b0;
        else                           nxt[i] = mFlags[i];
      end
      mFlags = nxt;
      mCnt = (mCnt + 1) % FULL;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitTick();
    do step(1); while (!tickPulse);
  endtask

  initial begin
    int t0;
    step(4);
    // R1: reset state
    @(negedge clk);
    check("R1", "flags in reset", int'(flags), 0);
    check("R1", "irq in reset", int'(irq), 0);
    rstN = 1'b1;
    t0 = 0;
    // R1: first tick for code 7 is 255 cycles after release
    do begin step(1); t0++; end while (!tickPulse);
    check("R1", "first tick cycle", t0, 255);
    step(1);
    check("R4", "tick flag after tick", int'(flags[1]), 1);

    // R6: clear tick flag with a one
    clrWr = 1'b1; clrData = 2'b10;
    step(1);
    clrWr = 1'b0; clrData = 2'b00;
    @(negedge clk);
    check("R6", "tick flag cleared", int'(flags[1]), 0);

    // R5 / R8: alarm with its enable off, then enabled
    step(1);
    alarmHit = 1'b1;
    step(1);
    alarmHit = 1'b0;
    @(negedge clk);
    check("R5", "alarm flag set", int'(flags[0]), 1);
    check("R8", "irq masked", int'(irq), 0);
    step(1);
    intEn = 2'b01;
    @(negedge clk);
    check("R8", "irq after enable", int'(irq), 1);
    check("R9", "wake after enable", int'(wakeReq), 1);

    // R6: writing zero leaves the alarm flag alone
    step(1);
    clrWr = 1'b1; clrData = 2'b00;
    step(1);
    clrWr = 1'b0;
    @(negedge clk);
    check("R6", "zero write ignored", int'(flags[0]), 1);

    // R7: alarm set and clear collide
    step(1);
    alarmHit = 1'b1; clrWr = 1'b1; clrData = 2'b01;
    step(1);
    alarmHit = 1'b0; clrWr = 1'b0; clrData = 2'b00;
    @(negedge clk);
    check("R7", "alarm set beats clear", int'(flags[0]), 1);

    // R7: tick and tick-flag clear in the same cycle
    intEn = 2'b10;
    waitTick();
    clrWr = 1'b1; clrData = 2'b11;
    step(1);
    clrWr = 1'b0; clrData = 2'b00;
    @(negedge clk);
    check("R7", "tick set beats clear", int'(flags[1]), 1);
    check("R6", "alarm cleared alongside", int'(flags[0]), 0);
    check("R8", "irq from tick", int'(irq), 1);

    // R2 / R3: walk the codes without restarting the divider
    for (int k = 6; k >= 0; k--) begin
      int gap;
      tickSel = 3'(k);
      waitTick();
      gap = 0;
      do begin step(1); gap++; end while (!tickPulse);
      check("R2", $sformatf("period code %0d", k), gap, FULL >> k);
      clrWr = 1'b1; clrData = 2'b10;
      step(1);
      clrWr = 1'b0; clrData = 2'b00;
    end
    step(20);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule